// File: doc/BRIEF.md
# SD Host Line Power Sequencer

This block owns the card-side pins of an SD/MMC host: the card clock, the command line and a parameterised set of data lines. Software steers it by writing a 2-bit power field over a simple write strobe and reading the field back. Depending on the field, every pin either floats, is driven high, is driven low, or carries the card clock and the values of the host datapath.

A dedicated power-on warm-up keeps the host core disabled while a fixed number of card clock periods go by. The count is taken from a card-clock enable strobe. After the count the core is released and the pins follow the datapath. Once power-on has been requested the field locks at 11, and only a hardware reset can clear it.

Floating after reset and driven high after an explicit write of 00 share the field value 00. A separate state output tells these two conditions apart.

Top module: `sd_line_pwrseq`

## Requirements
- R1: While reset is asserted and until the first field write, rd_data is 00 and line_state is 0 (floating). The data and command output enables are 0. The card clock pin is driven (enable 1) at value 0, and core_enable is 0.
- R2: Writing 00 from the floating, driven-high or driven-low state moves the block to line_state 1. All pins are enabled and driven at 1, rd_data reads 00, and core_enable stays 0.
- R3: Writing 10 from the floating, driven-high or driven-low state moves the block to line_state 2. All pins are enabled and driven at 0, rd_data reads 10, and core_enable stays 0.
- R4: Writing 11 from the floating, driven-high or driven-low state moves the block to line_state 3 (warm-up), and rd_data reads 11. The clock pin is enabled and carries card_ck. Command and data pins are enabled at 1, and core_enable is 0.
- R5: During warm-up, core_enable rises, and line_state becomes 4, on the cycle after the clock edge that samples the WARM_CYCLES-th (default 74) ck_stb pulse counted since warm-up began. Strobes seen before warm-up are not counted.
- R6: In line_state 4, the command and data pins take their value and output enable from core_cmd_o/core_cmd_oe and core_dat_o/core_dat_oe. The clock pin is enabled and carries card_ck.
- R7: While rd_data reads 11 (warm-up or run), every write is ignored: rd_data, line_state and the pins are unchanged.
- R8: A write of the reserved code 01 in any state leaves rd_data, line_state and the pins unchanged.
- R9: Asserting rst_n low from any state, including run, returns the block to the floating condition of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the power field |
| wr_data | input | 2 | Power field value to write |
| rd_data | output | 2 | Current power field value |
| ck_stb | input | 1 | One-cycle pulse per card clock period |
| card_ck | input | 1 | Card clock level from the divider |
| core_cmd_o | input | 1 | Command value from the host datapath |
| core_cmd_oe | input | 1 | Command output enable from the host datapath |
| core_dat_o | input | DW | Data values from the host datapath |
| core_dat_oe | input | DW | Data output enables from the host datapath |
| line_state | output | 3 | 0 floating, 1 high, 2 low, 3 warm-up, 4 run |
| core_enable | output | 1 | Host core enable |
| pad_ck_o | output | 1 | Card clock pin value |
| pad_ck_oe | output | 1 | Card clock pin output enable |
| pad_cmd_o | output | 1 | Command pin value |
| pad_cmd_oe | output | 1 | Command pin output enable |
| pad_dat_o | output | DW | Data pin values |
| pad_dat_oe | output | DW | Data pin output enables |

## Verification
The assertions assume that ck_stb is a single-cycle pulse synchronous to clk. They also assume that wr_en and wr_data are stable across the sampling edge, and that rst_n is released away from a clock edge. The stimulus changes every input only on falling clock edges and drops each strobe after one cycle. It also deliberately issues strobes outside warm-up, writes during warm-up and run, and reserved writes, so that the properties for ignored input are exercised rather than vacuous.

// File: rtl/sdpw_pkg.sv
package sdpw_pkg;

  typedef enum logic [2:0] {
    PS_FLOAT = 3'd0,
    PS_HIGH  = 3'd1,
    PS_LOW   = 3'd2,
    PS_WARM  = 3'd3,
    PS_RUN   = 3'd4
  } pstate_e;

  localparam logic [1:0] FLD_OFF = 2'b00;
  localparam logic [1:0] FLD_RSV = 2'b01;
  localparam logic [1:0] FLD_CYC = 2'b10;
  localparam logic [1:0] FLD_ON  = 2'b11;

  function automatic logic [1:0] field_of(pstate_e s);
    case (s)
      PS_LOW:          return FLD_CYC;
      PS_WARM, PS_RUN: return FLD_ON;
      default:         return FLD_OFF;
    endcase
  endfunction

  // Returns {oe, value} for a command or data pin.
  function automatic logic [1:0] sig_drive(pstate_e s, logic cv, logic coe);
    case (s)
      PS_HIGH, PS_WARM: return 2'b11;
      PS_LOW:           return 2'b10;
      PS_RUN:           return {coe, cv};
      default:          return 2'b00;
    endcase
  endfunction

  // Returns {oe, value} for the card clock pin.
  function automatic logic [1:0] ck_drive(pstate_e s, logic ck);
    case (s)
      PS_HIGH:         return 2'b11;
      PS_WARM, PS_RUN: return {1'b1, ck};
      default:         return 2'b10;
    endcase
  endfunction

endpackage

// File: rtl/sdpw_warmup.sv
module sdpw_warmup #(
  parameter int WARM_CYCLES = 74
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ck_stb,
  output logic last
);
  localparam int CW = $clog2(WARM_CYCLES + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(WARM_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = !active || ck_stb;
  assign last   = active && ck_stb && (cnt_q == LAST_IDX);

  always_comb begin
    cnt_d = cnt_q;
    if (!active)     cnt_d = '0;
    else if (ck_stb) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sdpw_ctrl.sv
module sdpw_ctrl
  import sdpw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  input  logic       warm_last,
  output pstate_e    state
);
  pstate_e st_q, st_d;
  logic    st_en;

  always_comb begin
    st_d = st_q;
    case (st_q)
      PS_FLOAT, PS_HIGH, PS_LOW: begin
        if (wr_en) begin
          case (wr_data)
            FLD_OFF: st_d = PS_HIGH;
            FLD_CYC: st_d = PS_LOW;
            FLD_ON:  st_d = PS_WARM;
            default: st_d = st_q;
          endcase
        end
      end
      PS_WARM: if (warm_last) st_d = PS_RUN;
      PS_RUN:  st_d = PS_RUN;
      default: st_d = PS_FLOAT;
    endcase
  end

  assign st_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= PS_FLOAT;
    else if (st_en) st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/sdpw_linemux.sv
module sdpw_linemux
  import sdpw_pkg::*;
#(
  parameter int DW = 8
) (
  input  pstate_e         state,
  input  logic            card_ck,
  input  logic            core_cmd_o,
  input  logic            core_cmd_oe,
  input  logic [DW-1:0]   core_dat_o,
  input  logic [DW-1:0]   core_dat_oe,
  output logic            pad_ck_o,
  output logic            pad_ck_oe,
  output logic            pad_cmd_o,
  output logic            pad_cmd_oe,
  output logic [DW-1:0]   pad_dat_o,
  output logic [DW-1:0]   pad_dat_oe
);
  assign {pad_ck_oe, pad_ck_o}   = ck_drive(state, card_ck);
  assign {pad_cmd_oe, pad_cmd_o} = sig_drive(state, core_cmd_o, core_cmd_oe);

  for (genvar i = 0; i < DW; i++) begin : g_dat
    assign {pad_dat_oe[i], pad_dat_o[i]} =
      sig_drive(state, core_dat_o[i], core_dat_oe[i]);
  end
endmodule

// File: rtl/sd_line_pwrseq.sv
module sd_line_pwrseq
  import sdpw_pkg::*;
#(
  parameter int DW          = 8,
  parameter int WARM_CYCLES = 74
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_data,
  output logic [1:0]    rd_data,
  input  logic          ck_stb,
  input  logic          card_ck,
  input  logic          core_cmd_o,
  input  logic          core_cmd_oe,
  input  logic [DW-1:0] core_dat_o,
  input  logic [DW-1:0] core_dat_oe,
  output logic [2:0]    line_state,
  output logic          core_enable,
  output logic          pad_ck_o,
  output logic          pad_ck_oe,
  output logic          pad_cmd_o,
  output logic          pad_cmd_oe,
  output logic [DW-1:0] pad_dat_o,
  output logic [DW-1:0] pad_dat_oe
);
  pstate_e state;
  logic    warm_last;

  sdpw_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .warm_last (warm_last),
    .state     (state)
  );

  sdpw_warmup #(.WARM_CYCLES(WARM_CYCLES)) u_warm (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (state == PS_WARM),
    .ck_stb (ck_stb),
    .last   (warm_last)
  );

  sdpw_linemux #(.DW(DW)) u_mux (
    .state       (state),
    .card_ck     (card_ck),
    .core_cmd_o  (core_cmd_o),
    .core_cmd_oe (core_cmd_oe),
    .core_dat_o  (core_dat_o),
    .core_dat_oe (core_dat_oe),
    .pad_ck_o    (pad_ck_o),
    .pad_ck_oe   (pad_ck_oe),
    .pad_cmd_o   (pad_cmd_o),
    .pad_cmd_oe  (pad_cmd_oe),
    .pad_dat_o   (pad_dat_o),
    .pad_dat_oe  (pad_dat_oe)
  );

  assign rd_data     = field_of(state);
  assign line_state  = state;
  assign core_enable = (state == PS_RUN);
endmodule

// File: rtl/sd_line_pwrseq_chk.sv
module sd_line_pwrseq_chk #(
  parameter int DW          = 8,
  parameter int WARM_CYCLES = 74
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_data,
  input logic          ck_stb,
  input logic [1:0]    rd_data,
  input logic [2:0]    line_state,
  input logic          core_enable,
  input logic          pad_ck_o,
  input logic          pad_ck_oe,
  input logic          pad_cmd_o,
  input logic          pad_cmd_oe,
  input logic [DW-1:0] pad_dat_o,
  input logic [DW-1:0] pad_dat_oe
);
  localparam int CW = $clog2(WARM_CYCLES + 2);

  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 seen <= '0;
    else if (line_state != 3'd3) seen <= '0;
    else if (ck_stb)            seen <= seen + CW'(1);
  end

  AST_FLOAT_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == 3'd0) |-> (rd_data == 2'b00 && pad_dat_oe == '0 && !pad_cmd_oe
                              && pad_ck_oe && !pad_ck_o && !core_enable)); // R1

  AST_HIGH_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == 3'd1) |-> (rd_data == 2'b00 && (&pad_dat_oe) && (&pad_dat_o)
                              && pad_cmd_oe && pad_cmd_o && pad_ck_o)); // R2

  AST_LOW_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == 3'd2) |-> (rd_data == 2'b10 && (&pad_dat_oe) && pad_dat_o == '0
                              && !pad_cmd_o && !pad_ck_o)); // R3

  AST_WARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == 3'd3) |-> (!core_enable && rd_data == 2'b11)); // R4

  AST_ENABLE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_enable) |-> (seen == CW'(WARM_CYCLES))); // R5

  AST_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == 3'd3) |-> (seen < CW'(WARM_CYCLES))); // R5

  AST_STICKY_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data == 2'b11) |=> (rd_data == 2'b11)); // R7

  AST_RSV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == 2'b01) |=> $stable(line_state)); // R8
endmodule

bind sd_line_pwrseq sd_line_pwrseq_chk #(.DW(DW), .WARM_CYCLES(WARM_CYCLES)) u_chk (.*);

// File: tb/sd_line_pwrseq_test.sv
module sd_line_pwrseq_test;
  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int WARM  = 74;

  typedef struct packed {
    logic [1:0]    rd;
    logic [2:0]    st;
    logic          ck_o, ck_oe, cmd_o, cmd_oe;
    logic [DW-1:0] dat_o, dat_oe;
    logic          en;
  } obs_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_data = 2'b00;
  logic ck_stb = 1'b0;
  logic card_ck = 1'b0;
  logic core_cmd_o = 1'b0, core_cmd_oe = 1'b0;
  logic [DW-1:0] core_dat_o = '0, core_dat_oe = '0;
  logic [1:0] rd_data;
  logic [2:0] line_state;
  logic core_enable, pad_ck_o, pad_ck_oe, pad_cmd_o, pad_cmd_oe;
  logic [DW-1:0] pad_dat_o, pad_dat_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  obs_t  exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  sd_line_pwrseq #(.DW(DW), .WARM_CYCLES(WARM)) uut (.*);

  // Expected pins for a given mode, built from the requirement text.
  function automatic obs_t model(int mode);
    obs_t e;
    e.st = 3'(mode);
    e.en = (mode == 4);
    case (mode)
      0: begin e.rd = 2'b00; e.ck_o = 0; e.ck_oe = 1; e.cmd_o = 0; e.cmd_oe = 0;
               e.dat_o = '0; e.dat_oe = '0; end
      1: begin e.rd = 2'b00; e.ck_o = 1; e.ck_oe = 1; e.cmd_o = 1; e.cmd_oe = 1;
               e.dat_o = '1; e.dat_oe = '1; end
      2: begin e.rd = 2'b10; e.ck_o = 0; e.ck_oe = 1; e.cmd_o = 0; e.cmd_oe = 1;
               e.dat_o = '0; e.dat_oe = '1; end
      3: begin e.rd = 2'b11; e.ck_o = card_ck; e.ck_oe = 1; e.cmd_o = 1; e.cmd_oe = 1;
               e.dat_o = '1; e.dat_oe = '1; end
      default: begin e.rd = 2'b11; e.ck_o = card_ck; e.ck_oe = 1;
               e.cmd_o = core_cmd_o; e.cmd_oe = core_cmd_oe;
               e.dat_o = core_dat_o; e.dat_oe = core_dat_oe; end
    endcase
    return e;
  endfunction

  // Driver side: called just after a rising edge; monitor compares later in that cycle.
  task automatic expect_mode(int mode, string tag);
    exp_q.push_back(model(mode));
    tag_q.push_back(tag);
  endtask

  task automatic wr(logic [1:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ck_stb = 1'b1;
      @(posedge clk); #1; ck_stb = 1'b0;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  // Monitor: pops expectations and compares mid-cycle.
  initial begin
    forever begin
      @(posedge clk); #3;
      while (exp_q.size() > 0) begin
        obs_t e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = '{rd_data, line_state, pad_ck_o, pad_ck_oe, pad_cmd_o, pad_cmd_oe,
              pad_dat_o, pad_dat_oe, core_enable};
        n_chk++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    expect_mode(0, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    idle(1); expect_mode(0, "R1 after release");
    wr(2'b01); expect_mode(0, "R8 reserved from float");
    wr(2'b00); expect_mode(1, "R2 driven high");
    wr(2'b10); expect_mode(2, "R3 power-cycle low");
    wr(2'b01); expect_mode(2, "R8 reserved from low");
    wr(2'b00); expect_mode(1, "R2 high after cycle");
    strobe(3); expect_mode(1, "R5 strobes before warm-up");
    @(negedge clk); card_ck = 1'b1;
    wr(2'b11); expect_mode(3, "R4 warm-up entered");
    wr(2'b00); expect_mode(3, "R7 write ignored in warm-up");
    wr(2'b01); expect_mode(3, "R8 reserved in warm-up");
    strobe(WARM - 1); expect_mode(3, "R5 still disabled after 73");
    idle(4); expect_mode(3, "R5 no strobe no progress");
    strobe(1); expect_mode(4, "R5 enable after last strobe");
    @(negedge clk); card_ck = 1'b0; core_cmd_o = 1'b0; core_cmd_oe = 1'b1;
    core_dat_o = 8'hA5; core_dat_oe = 8'h0F;
    idle(1); expect_mode(4, "R6 datapath pattern A");
    wr(2'b10); expect_mode(4, "R7 write 10 ignored in run");
    wr(2'b00); expect_mode(4, "R7 write 00 ignored in run");
    @(negedge clk); card_ck = 1'b1; core_cmd_o = 1'b1; core_cmd_oe = 1'b0;
    core_dat_o = 8'h3C; core_dat_oe = 8'hF0;
    idle(1); expect_mode(4, "R6 datapath pattern B");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    idle(1); expect_mode(0, "R9 reset from run");
    wr(2'b11); expect_mode(3, "R4 power-on straight from float");
    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule